// File: doc/BRIEF.md
# Serial Phase Alignment Delay Line

This block delays a single-bit serial stream by a programmable number of half periods of a fast clock. The fast clock runs at twice the deserializer's data-clock rate, which is ten times the frame rate. The purpose is to move each incoming bit so that it is steady when the deserializer samples it, ideally lagging the data-clock edges by a quarter of a bit. The same delay also makes bit 0 of every frame arrive at the first rising data-clock edge of that frame.

The delay is built from a chain of flip-flops. Two stages that fire on the same fast-clock edge add one whole fast period. A stage that fires on the opposite edge adds half a period, which is the finest step. The main chain has `NUM_STAGES` stages that all use the edge chosen by `MAIN_EDGE`, which is the falling edge by default. When `HALF_STEP` is 1, one more stage on the opposite edge follows the chain. The default is seven falling-edge stages. Counted from an input change, that gives between 6 and 7 fast periods of delay, depending on where the change falls relative to the clock.

Top module: `serial_phase_delay`

## Requirements
- R1: With the defaults (`NUM_STAGES`=7, `HALF_STEP`=0, falling-edge chain), the value of `ser_in` seen at a falling edge appears on `ser_out` right after the falling edge that comes 6 edges later. That is a delay of exactly `NUM_STAGES` falling edges, and it holds for every bit pattern.
- R2: With `HALF_STEP`=0, `ser_out` changes only at falling edges. Between a rising edge and the falling edge that follows, it still holds the bit captured at the earlier falling edge.
- R3: With `HALF_STEP`=1, `ser_out` is updated only at rising edges. After each rising edge it carries the last chain output. Sampled after a falling edge, it therefore lags the `HALF_STEP`=0 output by one bit.
- R4: While `rst` is high, the level on `ser_in` has no effect. Every stage is cleared to 0, and `ser_out` reads 0 until data sampled after reset has crossed the whole chain.
- R5: A reset lasting a single cycle in the middle of a stream takes effect at the next clock edge. It discards every bit held in the chain, so `ser_out` reads 0 until the first bit sampled after the reset comes out.
- R6: The output is the last stage of the delay. No combinational path exists from `ser_in` to `ser_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock at twice the data-clock rate |
| rst | input | 1 | Synchronous active-high reset, sampled on the edge each stage uses |
| ser_in | input | 1 | Incoming serial bit |
| ser_out | output | 1 | Delayed serial bit, driven straight from the last stage |

## Verification
The bench changes `ser_in` and `rst` 2 ns after each rising edge. It samples each output twice per cycle: 5 ns after the rising edge, and 5 ns after the falling edge. For the default instance, a bit driven in cycle k is due at the late sample of cycle k+6. At the early samples, the output still shows the bit from one cycle before. For the half-step instance, the bit from cycle k first appears at the early sample of cycle k+7. A reset driven in cycle r zeroes every expected value drawn from bits of cycles up to r. The bench keeps a record of every bit and every reset, so each expected value is looked up from that record.

// File: rtl/spd_pkg.sv
`timescale 1ns/1ps
package spd_pkg;
  typedef enum logic {
    SPD_RISE = 1'b0,
    SPD_FALL = 1'b1
  } spd_edge_e;

  function automatic spd_edge_e spd_opposite(input spd_edge_e e);
    return (e == SPD_FALL) ? SPD_RISE : SPD_FALL;
  endfunction
endpackage

// File: rtl/spd_edge_flop.sv
`timescale 1ns/1ps
module spd_edge_flop
  import spd_pkg::*;
#(
  parameter spd_edge_e EDGE = SPD_FALL
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (EDGE == SPD_FALL) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/spd_chain.sv
`timescale 1ns/1ps
module spd_chain
  import spd_pkg::*;
#(
  parameter int        NUM_STAGES = 7,
  parameter spd_edge_e EDGE       = SPD_FALL
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  d,
  output logic [NUM_STAGES-1:0] taps
);
  logic [NUM_STAGES:0] link;
  assign link[0] = d;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    spd_edge_flop #(.EDGE(EDGE)) u_ff (
      .clk (clk),
      .rst (rst),
      .d   (link[i]),
      .q   (link[i+1])
    );
  end

  assign taps = link[NUM_STAGES:1];
endmodule

// File: rtl/serial_phase_delay.sv
`timescale 1ns/1ps
module serial_phase_delay
  import spd_pkg::*;
#(
  parameter int        NUM_STAGES = 7,
  parameter bit        HALF_STEP  = 1'b0,
  parameter spd_edge_e MAIN_EDGE  = SPD_FALL
) (
  input  logic clk_fast,
  input  logic rst,
  input  logic ser_in,
  output logic ser_out
);
  localparam spd_edge_e OPP_EDGE = spd_opposite(MAIN_EDGE);
  localparam int        LAST     = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] taps_q;
  logic                  chain_out;

  spd_chain #(.NUM_STAGES(NUM_STAGES), .EDGE(MAIN_EDGE)) u_chain (
    .clk  (clk_fast),
    .rst  (rst),
    .d    (ser_in),
    .taps (taps_q)
  );

  assign chain_out = taps_q[LAST];

  generate
    if (HALF_STEP) begin : g_half
      spd_edge_flop #(.EDGE(OPP_EDGE)) u_half (
        .clk (clk_fast),
        .rst (rst),
        .d   (chain_out),
        .q   (ser_out)
      );
    end else begin : g_full
      assign ser_out = chain_out;
    end
  endgenerate
endmodule

// File: rtl/serial_phase_delay_chk.sv
`timescale 1ns/1ps
module serial_phase_delay_chk
  import spd_pkg::*;
#(
  parameter int        NUM_STAGES = 7,
  parameter bit        HALF_STEP  = 1'b0,
  parameter spd_edge_e MAIN_EDGE  = SPD_FALL
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ser_in,
  input logic [NUM_STAGES-1:0] taps,
  input logic                  ser_out
);
  logic main_clk;
  logic opp_clk;
  logic live_q;
  logic hlive_q;
  logic rst_q;

  assign main_clk = (MAIN_EDGE == SPD_FALL) ? ~clk : clk;
  assign opp_clk  = ~main_clk;

  always_ff @(posedge main_clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  always_ff @(posedge opp_clk) begin
    if (rst) hlive_q <= 1'b0;
    else     hlive_q <= 1'b1;
  end

  AST_FIRST_STAGE: assert property (@(posedge main_clk) disable iff (rst)
    live_q |-> taps[0] == $past(ser_in)) else $error("first stage"); // R1

  always_ff @(posedge main_clk) begin
    if (rst_q) begin
      AST_RESET_CLEARS: assert (taps == '0) else $error("reset clear"); // R4
    end
    rst_q <= rst;
  end

  generate
    if (NUM_STAGES > 1) begin : g_shift
      AST_SHIFT_ORDER: assert property (@(posedge main_clk) disable iff (rst)
        live_q |-> taps[NUM_STAGES-1:1] == $past(taps[NUM_STAGES-2:0])) else $error("shift"); // R1
    end
    if (HALF_STEP) begin : g_half
      AST_HALF_STEP: assert property (@(posedge opp_clk) disable iff (rst)
        hlive_q |-> ser_out == $past(taps[NUM_STAGES-1])) else $error("half step"); // R3
    end
  endgenerate
endmodule

bind serial_phase_delay serial_phase_delay_chk #(
  .NUM_STAGES (NUM_STAGES),
  .HALF_STEP  (HALF_STEP),
  .MAIN_EDGE  (MAIN_EDGE)
) u_chk (
  .clk     (clk_fast),
  .rst     (rst),
  .ser_in  (ser_in),
  .taps    (taps_q),
  .ser_out (ser_out)
);

// File: tb/serial_phase_delay_tb.sv
`timescale 1ns/1ps
module serial_phase_delay_tb;
  localparam int N    = 7;
  localparam int CYC  = 2000;
  localparam int MIDR = 110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic out_full;
  logic out_half;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  bit b_hist [0:CYC-1];
  bit r_hist [0:CYC-1];

  always #10 clk = ~clk;

  serial_phase_delay u_dut (
    .clk_fast (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .ser_out  (out_full)
  );

  serial_phase_delay #(.HALF_STEP(1'b1)) u_dut_half (
    .clk_fast (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .ser_out  (out_half)
  );

  function automatic logic expv(int idx, int lo, int hi);
    if (idx < 0) return 1'b0;
    for (int c = (lo < 0 ? 0 : lo); c <= hi; c++)
      if (r_hist[c]) return 1'b0;
    return b_hist[idx];
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_for(int j, string base);
    if (j < 6 + N) return "R4";
    if (j >= MIDR && j <= MIDR + N) return "R5";
    return base;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int j = 0; j < CYC; j++) begin
      bit rb, sb;
      @(posedge clk);
      #2;
      if (j < 6) begin rb = 1'b1; sb = 1'b1; end          // R4: input ignored in reset
      else if (j < 30)  begin rb = 1'b0; sb = j[0]; end
      else if (j < 50)  begin rb = 1'b0; sb = 1'b1; end
      else if (j < 70)  begin rb = 1'b0; sb = 1'b0; end
      else if (j < 100) begin rb = 1'b0; sb = (j % 9 == 0); end
      else if (j < 140) begin rb = (j == MIDR); sb = 1'b1; end // R5
      else begin
        sb = $urandom() & 1;
        rb = (($urandom() % 97) == 0);
      end
      rst = rb; ser_in = sb;
      r_hist[j] = rb; b_hist[j] = sb;
      #3;
      if (j >= 2) begin
        chk(tag_for(j, "R2"), out_full, expv(j - N, j - N, j - 1));
        chk(tag_for(j, "R3"), out_half, expv(j - N, j - N, j - 1));
      end
      #10;
      if (j >= 2) begin
        chk(tag_for(j, "R1"), out_full, expv(j - N + 1, j - N + 1, j));
        chk(tag_for(j, "R3"), out_half, expv(j - N, j - N, j - 1));
      end
      if (j == 3) chk("R4", out_full, 1'b0);
      if (j == 60) chk("R6", out_full, b_hist[j - N + 1]);
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(100000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule